// File: doc/BRIEF.md
# Suspend Modulation Throttle Controller

This block slows a processor by pulsing an active-low suspend line. Software programs two byte-wide durations, a run length and a suspend length, both counted in ticks of 32 µs. While modulation is enabled, the controller alternates between holding the line released for the run length and holding it asserted for the suspend length. The processor's effective rate is then its full rate scaled by run/(run + suspend).

Two activity inputs, one for interrupts and one for video, can open a temporary speedup window. During the window throttling stops and the processor runs at full speed. Each window lasts a programmed number of milliseconds. A further event of the same kind restarts the window. When every window has closed, modulation starts again from the beginning of a run phase. A byte-wide register port sets up the controller, and every register reads back the value last written. The 32 µs tick comes from a prescaler on the input clock. The millisecond timebase is built from that tick with a fractional accumulator, using 31.25 ticks per ms.

Top module: `suspmod_throttle`

## Requirements
- R1: After reset every register reads 0x00 and `susp_n` is high.
- R2: Registers are at these offsets: 0x80 power-management enable, 0x8C interrupt window (ms), 0x8D video window (ms), 0x94 suspend length, 0x95 run length, 0x96 modulation config. A write updates the register on the clock edge. `reg_rdata` shows the register at `reg_addr` combinationally. Any other offset reads 0x00.
- R3: Modulation is enabled when config bit 0 is 1 and the suspend length S is nonzero. Starting from the edge that enables it, `susp_n` is high for R·TICK_DIV cycles and then low for S·TICK_DIV cycles, and this repeats. R is the run length.
- R4: While config bit 0 is 0, `susp_n` is high. This takes effect in the cycle after the write that clears the bit.
- R5: A suspend length of 0 keeps `susp_n` high whatever the other settings are.
- R6: A run length of 0, with modulation enabled and no speedup window open, keeps `susp_n` low continuously.
- R7: A new run or suspend length written during modulation does not change the phase in progress. It is used from the next phase boundary onward.
- R8: An interrupt event opens a window when enable bit 0 (global) and bit 3 are both set and the interrupt window value V is nonzero. A video event does the same with bit 0 and bit 4 and the video window value. From the cycle after the event until the window closes, `susp_n` is high. The window closes on the V-th millisecond boundary after the most recent event, so it lasts between V−1 and V ms. Every new event reloads V.
- R9: An event has no effect when its enable bit is clear, when the global bit is clear, or when its window value is 0.
- R10: When all windows have closed, modulation restarts at the start of a run phase. If the run length is 0, it restarts directly in the suspend phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock feeding the prescaler |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_evt | input | 1 | Interrupt activity pulse |
| vid_evt | input | 1 | Video activity pulse |
| susp_n | output | 1 | Active-low suspend request to the processor |

## Verification
The bench compares the exact edge positions of `susp_n` against a period model over random run and suspend lengths. A wrong prescaler or off-by-one phase counter would shift every edge. The zero-length cases are driven on purpose. A design that mishandled a zero suspend length would assert suspend, and one that mishandled a zero run length would leak one-tick release pulses. A run length is rewritten partway through a run to catch a design that cuts the current phase short. Speedup events are fired with their enable or window value missing, which a careless decode would accept, and as a retriggering train, which a non-reloading timer would let lapse. Each window must also end in a fresh run phase rather than resuming the old phase.

// File: rtl/suspmod_pkg.sv
package suspmod_pkg;

    localparam int REG_W = 8;

    localparam logic [7:0] OFS_PMEN    = 8'h80;
    localparam logic [7:0] OFS_IRQ_WIN = 8'h8C;
    localparam logic [7:0] OFS_VID_WIN = 8'h8D;
    localparam logic [7:0] OFS_SUSP    = 8'h94;
    localparam logic [7:0] OFS_RUN     = 8'h95;
    localparam logic [7:0] OFS_CFG     = 8'h96;

    localparam int PM_GLOBAL_BIT = 0;
    localparam int PM_IRQ_BIT    = 3;
    localparam int PM_VID_BIT    = 4;
    localparam int CFG_EN_BIT    = 0;

    localparam int NUM_SRC = 2;
    localparam int SRC_IRQ = 0;
    localparam int SRC_VID = 1;

    typedef struct packed {
        logic [REG_W-1:0] pmen;
        logic [REG_W-1:0] irq_win;
        logic [REG_W-1:0] vid_win;
        logic [REG_W-1:0] susp_len;
        logic [REG_W-1:0] run_len;
        logic [REG_W-1:0] cfg;
    } ctl_regs_t;

    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_SUSP = 1'b1
    } phase_e;

    function automatic logic [REG_W-1:0] read_mux(input ctl_regs_t r, input logic [7:0] a);
        logic [REG_W-1:0] d;
        case (a)
            OFS_PMEN:    d = r.pmen;
            OFS_IRQ_WIN: d = r.irq_win;
            OFS_VID_WIN: d = r.vid_win;
            OFS_SUSP:    d = r.susp_len;
            OFS_RUN:     d = r.run_len;
            OFS_CFG:     d = r.cfg;
            default:     d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/suspmod_regs.sv
module suspmod_regs
    import suspmod_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [7:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output ctl_regs_t        regs
);

    ctl_regs_t regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr) begin
            case (addr)
                OFS_PMEN:    regs_q.pmen     <= wdata;
                OFS_IRQ_WIN: regs_q.irq_win  <= wdata;
                OFS_VID_WIN: regs_q.vid_win  <= wdata;
                OFS_SUSP:    regs_q.susp_len <= wdata;
                OFS_RUN:     regs_q.run_len  <= wdata;
                OFS_CFG:     regs_q.cfg      <= wdata;
                default:     ;
            endcase
        end
    end

    assign regs  = regs_q;
    assign rdata = read_mux(regs_q, addr);

    AST_WR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFS_RUN) |=> (regs_q.run_len == $past(wdata))); // R2

endmodule

// File: rtl/suspmod_timebase.sv
module suspmod_timebase #(
    parameter int TICK_DIV = 1600,
    parameter int MS_NUM   = 4,
    parameter int MS_DEN   = 125
) (
    input  logic clk,
    input  logic rst,
    output logic ms_pulse
);

    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int AW = $clog2(MS_NUM + MS_DEN) + 1;

    logic [CW-1:0] pre_q;
    logic [AW-1:0] acc_q;
    logic [AW-1:0] acc_sum;
    logic          tick;

    assign tick    = (pre_q == CW'(TICK_DIV - 1));
    assign acc_sum = acc_q + AW'(MS_NUM);
    assign ms_pulse = tick && (acc_sum >= AW'(MS_DEN));

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            acc_q <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) begin
                acc_q <= ms_pulse ? acc_sum - AW'(MS_DEN) : acc_sum;
            end
        end
    end

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
        acc_q < AW'(MS_DEN)); // R8

endmodule

// File: rtl/suspmod_speedup.sv
module suspmod_speedup
    import suspmod_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             en,
    input  logic [REG_W-1:0] load_val,
    input  logic             ms_pulse,
    output logic             busy
);

    logic [REG_W-1:0] cnt_q;
    logic             fire;

    assign fire = evt && en && (load_val != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (fire) begin
            cnt_q <= load_val;
        end else if (ms_pulse && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

    AST_WIN_OPENS: assert property (@(posedge clk) disable iff (rst)
        (evt && en && load_val != '0) |=> busy); // R8
    AST_WIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(evt && en && load_val != '0)) |=> !busy); // R9

endmodule

// File: rtl/suspmod_phase.sv
module suspmod_phase
    import suspmod_pkg::*;
#(
    parameter int TICK_DIV = 1600
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mod_on,
    input  logic             hold,
    input  logic [REG_W-1:0] run_len,
    input  logic [REG_W-1:0] susp_len,
    output logic             susp_n
);

    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    phase_e           phase_q;
    logic [REG_W-1:0] elapsed_q;
    logic [REG_W-1:0] cur_len_q;
    logic [CW-1:0]    pre_q;
    logic             restart;
    logic             tick;
    logic             at_end;

    assign restart = !mod_on || hold;
    assign tick    = !restart && (pre_q == CW'(TICK_DIV - 1));
    assign at_end  = ({1'b0, elapsed_q} + 9'd1) >= {1'b0, cur_len_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (restart || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_RUN;
            elapsed_q <= '0;
            cur_len_q <= '0;
        end else if (restart) begin
            elapsed_q <= '0;
            if (run_len == '0) begin
                phase_q   <= PH_SUSP;
                cur_len_q <= susp_len;
            end else begin
                phase_q   <= PH_RUN;
                cur_len_q <= run_len;
            end
        end else if (tick) begin
            if (at_end) begin
                elapsed_q <= '0;
                if (phase_q == PH_RUN || run_len == '0) begin
                    phase_q   <= PH_SUSP;
                    cur_len_q <= susp_len;
                end else begin
                    phase_q   <= PH_RUN;
                    cur_len_q <= run_len;
                end
            end else begin
                elapsed_q <= elapsed_q + 1'b1;
            end
        end
    end

    assign susp_n = !(phase_q == PH_SUSP && !restart);

    AST_RUN0_STAYS: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SUSP && !restart && run_len == '0) |=> (phase_q == PH_SUSP)); // R6
    AST_LEN_HELD: assert property (@(posedge clk) disable iff (rst)
        (!restart && !(tick && at_end)) |=> $stable(cur_len_q)); // R7

endmodule

// File: rtl/suspmod_throttle.sv
module suspmod_throttle
    import suspmod_pkg::*;
#(
    parameter int TICK_DIV = 1600,
    parameter int MS_NUM   = 4,
    parameter int MS_DEN   = 125
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       irq_evt,
    input  logic       vid_evt,
    output logic       susp_n
);

    ctl_regs_t              regs;
    logic                   ms_pulse;
    logic                   mod_on;
    logic                   hold;
    logic [NUM_SRC-1:0]     evt_vec;
    logic [NUM_SRC-1:0]     en_vec;
    logic [NUM_SRC-1:0]     busy_vec;
    logic [REG_W-1:0]       win_val [NUM_SRC];

    suspmod_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .regs  (regs)
    );

    suspmod_timebase #(
        .TICK_DIV (TICK_DIV),
        .MS_NUM   (MS_NUM),
        .MS_DEN   (MS_DEN)
    ) u_timebase (
        .clk      (clk),
        .rst      (rst),
        .ms_pulse (ms_pulse)
    );

    assign evt_vec[SRC_IRQ] = irq_evt;
    assign evt_vec[SRC_VID] = vid_evt;
    assign en_vec[SRC_IRQ]  = regs.pmen[PM_GLOBAL_BIT] & regs.pmen[PM_IRQ_BIT];
    assign en_vec[SRC_VID]  = regs.pmen[PM_GLOBAL_BIT] & regs.pmen[PM_VID_BIT];
    assign win_val[SRC_IRQ] = regs.irq_win;
    assign win_val[SRC_VID] = regs.vid_win;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_spd
        suspmod_speedup u_spd (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt_vec[g]),
            .en       (en_vec[g]),
            .load_val (win_val[g]),
            .ms_pulse (ms_pulse),
            .busy     (busy_vec[g])
        );
    end

    assign hold   = |busy_vec;
    assign mod_on = regs.cfg[CFG_EN_BIT] && (regs.susp_len != '0);

    suspmod_phase #(
        .TICK_DIV (TICK_DIV)
    ) u_phase (
        .clk      (clk),
        .rst      (rst),
        .mod_on   (mod_on),
        .hold     (hold),
        .run_len  (regs.run_len),
        .susp_len (regs.susp_len),
        .susp_n   (susp_n)
    );

    AST_WIN_RELEASES: assert property (@(posedge clk) disable iff (rst)
        hold |-> susp_n); // R8
    AST_DISABLED_HIGH: assert property (@(posedge clk) disable iff (rst)
        !regs.cfg[CFG_EN_BIT] |-> susp_n); // R4
    AST_ZERO_SUSP: assert property (@(posedge clk) disable iff (rst)
        !susp_n |-> (regs.susp_len != '0)); // R5

endmodule

// File: tb/suspmod_throttle_bench.sv
module suspmod_throttle_bench;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_evt = 1'b0;
    logic       vid_evt = 1'b0;
    logic       susp_n;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    suspmod_throttle #(.TICK_DIV(DIV), .MS_NUM(4), .MS_DEN(125)) u_suspmod_throttle (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_evt   (irq_evt),
        .vid_evt   (vid_evt),
        .susp_n    (susp_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic bit exp_high(input int n, input int r, input int s);
        int p;
        p = (r + s) * DIV;
        return (n % p) < (r * DIV);
    endfunction

    // Period model check over a window starting at the enabling edge (R3)
    task automatic run_mod(input int r, input int s, input int cycles);
        int miss = 0;
        int first_n = -1;
        int first_v = 0;
        wr(8'h96, 8'h00);
        wr(8'h95, 8'(r));
        wr(8'h94, 8'(s));
        wr(8'h96, 8'h01);
        for (int n = 0; n < cycles; n++) begin
            if (susp_n !== exp_high(n, r, s)) begin
                if (first_n < 0) begin first_n = n; first_v = int'(susp_n); end
                miss++;
            end
            @(negedge clk);
        end
        chk(miss == 0, $sformatf("R3 pattern run=%0d susp=%0d at n=%0d", r, s, first_n),
            first_v, int'(!first_v));
        wr(8'h96, 8'h00);
        chk(susp_n === 1'b1, "R4 disable releases", int'(susp_n), 1);
    endtask

    task automatic pulse(input bit is_irq);
        @(negedge clk);
        if (is_irq) irq_evt = 1'b1; else vid_evt = 1'b1;
        @(negedge clk);
        irq_evt = 1'b0; vid_evt = 1'b0;
    endtask

    task automatic watch_low(input int cycles, input string req);
        int highs = 0;
        for (int i = 0; i < cycles; i++) begin
            if (susp_n !== 1'b0) highs++;
            @(negedge clk);
        end
        chk(highs == 0, req, highs, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] offs [6];
        logic [7:0] vals [6];
        int highs;
        int t;
        void'($urandom(32'd4242));
        offs = '{8'h80, 8'h8C, 8'h8D, 8'h94, 8'h95, 8'h96};
        vals = '{8'hA5, 8'h3C, 8'hC3, 8'h5A, 8'h7E, 8'hFE};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(susp_n === 1'b1, "R1 susp_n after reset", int'(susp_n), 1);
        for (int i = 0; i < 6; i++) begin
            reg_addr = offs[i]; #1;
            chk(reg_rdata === 8'h00, $sformatf("R1 reset reg 0x%0h", offs[i]), int'(reg_rdata), 0);
        end

        // R2 read-back and unmapped offset
        for (int i = 0; i < 6; i++) wr(offs[i], vals[i]);
        for (int i = 0; i < 6; i++) begin
            reg_addr = offs[i]; #1;
            chk(reg_rdata === vals[i], $sformatf("R2 readback 0x%0h", offs[i]), int'(reg_rdata), int'(vals[i]));
        end
        reg_addr = 8'h90; #1;
        chk(reg_rdata === 8'h00, "R2 unmapped reads zero", int'(reg_rdata), 0);
        for (int i = 0; i < 6; i++) wr(offs[i], 8'h00);

        // R3 directed and random patterns
        run_mod(1, 1, 40);
        run_mod(3, 5, 100);
        for (int k = 0; k < 6; k++) begin
            int r = 1 + int'($urandom % 7);
            int s = 1 + int'($urandom % 6);
            run_mod(r, s, 3 * (r + s) * DIV + 5);
        end

        // R5 zero suspend length never asserts
        wr(8'h95, 8'd2); wr(8'h94, 8'd0); wr(8'h96, 8'h01);
        highs = 0;
        for (int i = 0; i < 200; i++) begin
            if (susp_n === 1'b1) highs++;
            @(negedge clk);
        end
        chk(highs == 200, "R5 zero suspend length", highs, 200);
        wr(8'h96, 8'h00);

        // R7 mid-phase rewrite of run length
        wr(8'h95, 8'd3); wr(8'h94, 8'd2); wr(8'h96, 8'h01);
        begin
            int miss = 0;
            for (int n = 0; n < 46; n++) begin
                bit e;
                e = (n < 20) ? exp_high(n, 3, 2) : exp_high(n - 20, 1, 2);
                if (susp_n !== e) miss++;
                if (n == 5) begin reg_wr = 1'b1; reg_addr = 8'h95; reg_wdata = 8'd1; end
                if (n == 6) reg_wr = 1'b0;
                @(negedge clk);
            end
            chk(miss == 0, "R7 new length at boundary", miss, 0);
        end
        wr(8'h96, 8'h00);

        // R6 zero run length holds suspend
        wr(8'h95, 8'd0); wr(8'h94, 8'd3); wr(8'h96, 8'h01);
        watch_low(100, "R6 run zero continuous suspend");

        // R9 events that must be ignored
        wr(8'h8C, 8'd2); wr(8'h8D, 8'd0); wr(8'h80, 8'h08);
        pulse(1'b1); watch_low(30, "R9 global bit clear ignores irq");
        wr(8'h80, 8'h11);
        pulse(1'b1); watch_low(30, "R9 irq enable clear ignores irq");
        wr(8'h80, 8'h19);
        pulse(1'b0); watch_low(30, "R9 zero video window ignores video");

        // R8 interrupt window, then R10 resume
        pulse(1'b1);
        highs = 0;
        for (int i = 0; i < 120; i++) begin
            if (susp_n === 1'b1) highs++;
            @(negedge clk);
        end
        chk(highs == 120, "R8 irq window holds release", highs, 120);
        t = 0;
        while (susp_n !== 1'b0 && t < 400) begin t++; @(negedge clk); end
        chk(t < 400, "R10 suspend resumes after window", t, 0);
        watch_low(20, "R10 suspend steady after window");

        // R8 retriggered video window
        wr(8'h8D, 8'd2);
        highs = 0;
        for (int k = 0; k < 10; k++) begin
            pulse(1'b0);
            for (int i = 0; i < 48; i++) begin
                if (susp_n !== 1'b1) highs++;
                @(negedge clk);
            end
        end
        chk(highs == 0, "R8 retrigger keeps window open", highs, 0);
        t = 0;
        while (susp_n !== 1'b0 && t < 400) begin t++; @(negedge clk); end
        chk(t < 400, "R8 retriggered window closes", t, 0);

        // R10 restart at run phase: release stretch covers a full run phase
        wr(8'h96, 8'h00);
        wr(8'h95, 8'd2); wr(8'h94, 8'd30); wr(8'h8C, 8'd1);
        wr(8'h96, 8'h01);
        repeat (20) @(negedge clk);
        pulse(1'b1);
        t = 0;
        while (susp_n === 1'b1 && t < 400) begin t++; @(negedge clk); end
        chk(t > 2 * DIV, "R10 run phase follows window", t, 2 * DIV + 1);
        watch_low(30 * DIV, "R10 full suspend phase after run");
        highs = 0;
        for (int i = 0; i < 2 * DIV; i++) begin
            if (susp_n === 1'b1) highs++;
            @(negedge clk);
        end
        chk(highs == 2 * DIV, "R10 next run phase length", highs, 2 * DIV);

        wr(8'h96, 8'h00);
        chk(susp_n === 1'b1, "R4 final disable", int'(susp_n), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule